// File: doc/BRIEF.md
# Oscillator Reprogramming Control Engine

This block is the register-side controller that reprograms the synthesizer of a programmable clock device. A host writes 16-bit words through an address/data/strobe port. The block keeps the words that hold the feedback divider, the post-divider and the output-divider mode. It also keeps two small fields that set the drive swing. When the reprogramming sequence runs, the block decodes the stored words into a true integer-plus-fraction feedback divider and a true post-divider, and hands them to the PLL.

The clock output is gated around each reprogramming. Writing the upper feedback-divider word turns the output off at once. Writing the post-divider word commits the new settings: the block checks that the post-divider is legal, pulses an apply strobe to the PLL, and waits for lock. The output comes back only after lock. An illegal post-divider, or a lock that does not arrive within a programmable number of cycles, leaves the output off and raises an error flag. The next valid commit clears that flag.

Top module: `osc_reprog_ctrl`

## Requirements
- R1: After reset, out_en_o is 1, pll_apply_o, err_range_o and err_lock_o are 0, and fb_int_o, fb_frac_o, post_div_o, drv_bypass_o, swing_a_o and swing_b_o are all 0.
- R2: A write to address 3 drives out_en_o to 0 on the clock edge that accepts the write.
- R3: A write to address 5 is a commit. If it is valid, pll_apply_o is 1 for exactly one cycle, starting at the edge that accepts the write. On that same edge the applied outputs load as follows. fb_int_o takes the last address-3 data bits [15:11] XOR 5'b01110. fb_frac_o takes {address-3 bits [10:0], address-4 bits [15:0]}. post_div_o takes the commit data bits [15:3] XOR 13'h001B. drv_bypass_o takes the last address-6 bit 3.
- R4: After a valid commit, out_en_o stays 0 until pll_lock_i is sampled high. It then becomes 1 on the edge that samples the lock.
- R5: A commit whose decoded post-divider is below 2 is rejected. The block gives no apply pulse, sets err_range_o, keeps out_en_o at 0 and leaves the applied outputs unchanged.
- R6: If pll_lock_i stays low for LOCK_TIMEOUT cycles after a valid commit, err_lock_o is set. out_en_o then stays 0, even if lock arrives later.
- R7: A write to address 5 loads data bits [2:0] into swing_a_o, and a write to address 6 loads data bits [2:0] into swing_b_o. Each takes effect on the accepting edge, whether or not a commit is accepted.
- R8: A valid commit clears err_range_o and err_lock_o.
- R9: Writes to addresses other than 3, 4, 5 and 6 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 16 | Write data |
| pll_lock_i | input | 1 | PLL lock indication |
| pll_apply_o | output | 1 | One-cycle strobe: load the new divider settings |
| fb_int_o | output | 5 | Applied feedback divider, integer part |
| fb_frac_o | output | 27 | Applied feedback divider, fraction part |
| post_div_o | output | 13 | Applied post-divider |
| drv_bypass_o | output | 1 | Applied output divider mode (1 = divide by 1, 0 = divide by 2) |
| swing_a_o | output | 3 | Drive swing field, first group |
| swing_b_o | output | 3 | Drive swing field, second group |
| out_en_o | output | 1 | Clock output enable |
| err_range_o | output | 1 | Last commit had an illegal post-divider |
| err_lock_o | output | 1 | Lock timeout after the last commit |

## Verification
Suppose the sequencer is stuck in the wrong state, for example in the running state when it should be waiting. out_en_o then goes high on the first edge after a commit without lock, so a check one cycle after the commit catches it. A stored word that is decoded or masked wrongly appears on fb_int_o, fb_frac_o or post_div_o on the same edge as the apply pulse. A fault in the timer shows up only at the LOCK_TIMEOUT boundary, so the bench samples err_lock_o one cycle before that boundary and again on it.

// File: rtl/osc_pkg.sv
package osc_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_BLANK = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FAULT = 2'd3
  } seq_state_e;

  localparam logic [4:0]  FB_INT_MASK = 5'b01110;
  localparam logic [12:0] POST_MASK   = 13'h001B;
  localparam logic [2:0]  ADDR_FB_HI  = 3'd3;
  localparam logic [2:0]  ADDR_FB_LO  = 3'd4;
  localparam logic [2:0]  ADDR_POST   = 3'd5;
  localparam logic [2:0]  ADDR_MODE   = 3'd6;
  localparam int unsigned POST_MIN    = 2;
endpackage

// File: rtl/osc_regfile.sv
module osc_regfile
  import osc_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned SW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] fb_hi_o,
  output logic [DW-1:0] fb_lo_o,
  output logic          mode_o,
  output logic [SW-1:0] swing_a_o,
  output logic [SW-1:0] swing_b_o,
  output logic          fb_hi_wr_o,
  output logic          commit_o
);
  assign fb_hi_wr_o = wr_en_i && (wr_addr_i == ADDR_FB_HI);
  assign commit_o   = wr_en_i && (wr_addr_i == ADDR_POST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fb_hi_o   <= '0;
      fb_lo_o   <= '0;
      mode_o    <= 1'b0;
      swing_a_o <= '0;
      swing_b_o <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_FB_HI: fb_hi_o <= wr_data_i;
        ADDR_FB_LO: fb_lo_o <= wr_data_i;
        ADDR_POST:  swing_a_o <= wr_data_i[SW-1:0];
        ADDR_MODE: begin
          swing_b_o <= wr_data_i[SW-1:0];
          mode_o    <= wr_data_i[SW];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/osc_div_decode.sv
module osc_div_decode
  import osc_pkg::*;
#(
  parameter int unsigned IW = 5,
  parameter int unsigned FW = 27,
  parameter int unsigned PW = 13
) (
  input  logic [IW+FW-1:0] fb_raw_i,
  input  logic [PW-1:0]    post_raw_i,
  output logic [IW-1:0]    fb_int_o,
  output logic [FW-1:0]    fb_frac_o,
  output logic [PW-1:0]    post_div_o,
  output logic             post_ok_o
);
  assign fb_int_o   = fb_raw_i[IW+FW-1:FW] ^ FB_INT_MASK;
  assign fb_frac_o  = fb_raw_i[FW-1:0];
  assign post_div_o = post_raw_i ^ POST_MASK;
  // upper bound equals the field maximum, only the floor can fail
  assign post_ok_o  = post_div_o >= PW'(POST_MIN);
endmodule

// File: rtl/osc_seq.sv
module osc_seq
  import osc_pkg::*;
#(
  parameter int unsigned IW          = 5,
  parameter int unsigned FW          = 27,
  parameter int unsigned PW          = 13,
  parameter int unsigned LOCK_TIMEOUT = 4096,
  localparam int unsigned TW         = (LOCK_TIMEOUT > 1) ? $clog2(LOCK_TIMEOUT) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fb_hi_wr_i,
  input  logic          commit_i,
  input  logic          post_ok_i,
  input  logic [IW-1:0] fb_int_i,
  input  logic [FW-1:0] fb_frac_i,
  input  logic [PW-1:0] post_div_i,
  input  logic          mode_i,
  input  logic          pll_lock_i,
  output logic          pll_apply_o,
  output logic [IW-1:0] fb_int_o,
  output logic [FW-1:0] fb_frac_o,
  output logic [PW-1:0] post_div_o,
  output logic          drv_bypass_o,
  output logic          out_en_o,
  output logic          err_range_o,
  output logic          err_lock_o
);
  seq_state_e    state_q;
  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_RUN;
      tmr_q        <= '0;
      pll_apply_o  <= 1'b0;
      fb_int_o     <= '0;
      fb_frac_o    <= '0;
      post_div_o   <= '0;
      drv_bypass_o <= 1'b0;
      out_en_o     <= 1'b1;
      err_range_o  <= 1'b0;
      err_lock_o   <= 1'b0;
    end else begin
      pll_apply_o <= 1'b0;
      if (commit_i) begin
        out_en_o <= 1'b0;
        tmr_q    <= '0;
        if (post_ok_i) begin
          state_q      <= ST_WAIT;
          pll_apply_o  <= 1'b1;
          fb_int_o     <= fb_int_i;
          fb_frac_o    <= fb_frac_i;
          post_div_o   <= post_div_i;
          drv_bypass_o <= mode_i;
          err_range_o  <= 1'b0;
          err_lock_o   <= 1'b0;
        end else begin
          state_q     <= ST_FAULT;
          err_range_o <= 1'b1;
        end
      end else if (fb_hi_wr_i) begin
        out_en_o <= 1'b0;
        if (state_q != ST_FAULT) state_q <= ST_BLANK;
      end else if (state_q == ST_WAIT) begin
        if (pll_lock_i) begin
          state_q  <= ST_RUN;
          out_en_o <= 1'b1;
        end else if (tmr_q == TW'(LOCK_TIMEOUT - 1)) begin
          state_q    <= ST_FAULT;
          err_lock_o <= 1'b1;
        end else begin
          tmr_q <= tmr_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/osc_reprog_ctrl.sv
module osc_reprog_ctrl
  import osc_pkg::*;
#(
  parameter int unsigned LOCK_TIMEOUT = 4096,
  localparam int unsigned DW = 16,
  localparam int unsigned IW = 5,
  localparam int unsigned FW = 27,
  localparam int unsigned PW = 13,
  localparam int unsigned SW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          pll_lock_i,
  output logic          pll_apply_o,
  output logic [IW-1:0] fb_int_o,
  output logic [FW-1:0] fb_frac_o,
  output logic [PW-1:0] post_div_o,
  output logic          drv_bypass_o,
  output logic [SW-1:0] swing_a_o,
  output logic [SW-1:0] swing_b_o,
  output logic          out_en_o,
  output logic          err_range_o,
  output logic          err_lock_o
);
  logic [DW-1:0] fb_hi, fb_lo;
  logic          mode, fb_hi_wr, commit, post_ok;
  logic [IW-1:0] dec_int;
  logic [FW-1:0] dec_frac;
  logic [PW-1:0] dec_post;

  osc_regfile #(.DW(DW), .SW(SW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .fb_hi_o(fb_hi), .fb_lo_o(fb_lo), .mode_o(mode),
    .swing_a_o, .swing_b_o,
    .fb_hi_wr_o(fb_hi_wr), .commit_o(commit)
  );

  osc_div_decode #(.IW(IW), .FW(FW), .PW(PW)) u_dec (
    .fb_raw_i({fb_hi, fb_lo}),
    .post_raw_i(wr_data_i[DW-1:SW]),
    .fb_int_o(dec_int), .fb_frac_o(dec_frac),
    .post_div_o(dec_post), .post_ok_o(post_ok)
  );

  osc_seq #(.IW(IW), .FW(FW), .PW(PW), .LOCK_TIMEOUT(LOCK_TIMEOUT)) u_seq (
    .clk_i, .rst_ni,
    .fb_hi_wr_i(fb_hi_wr), .commit_i(commit), .post_ok_i(post_ok),
    .fb_int_i(dec_int), .fb_frac_i(dec_frac), .post_div_i(dec_post),
    .mode_i(mode), .pll_lock_i,
    .pll_apply_o, .fb_int_o, .fb_frac_o, .post_div_o, .drv_bypass_o,
    .out_en_o, .err_range_o, .err_lock_o
  );
endmodule

// File: rtl/osc_reprog_ctrl_chk.sv
module osc_reprog_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [2:0]  wr_addr_i,
  input logic [15:0] wr_data_i,
  input logic        pll_lock_i,
  input logic        pll_apply_o,
  input logic [12:0] post_div_o,
  input logic [2:0]  swing_b_o,
  input logic        out_en_o,
  input logic        err_range_o,
  input logic        err_lock_o
);
  p_blank_on_fb_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'd3) |=> !out_en_o);

  p_apply_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_apply_o |=> !pll_apply_o);

  p_enable_after_lock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_en_o) |-> $past(pll_lock_i));

  p_post_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_apply_o |-> (post_div_o >= 13'd2));

  p_fault_dark_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_range_o || err_lock_o) |-> !out_en_o);

  p_swing_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'd6) |=> (swing_b_o == $past(wr_data_i[2:0])));
endmodule

bind osc_reprog_ctrl osc_reprog_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .pll_lock_i(pll_lock_i), .pll_apply_o(pll_apply_o),
  .post_div_o(post_div_o), .swing_b_o(swing_b_o), .out_en_o(out_en_o),
  .err_range_o(err_range_o), .err_lock_o(err_lock_o)
);

// File: tb/osc_reprog_ctrl_tb.sv
module osc_reprog_ctrl_tb;
  localparam int TMO = 16;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        pll_lock_i = 1'b0;
  logic        pll_apply_o, drv_bypass_o, out_en_o, err_range_o, err_lock_o;
  logic [4:0]  fb_int_o;
  logic [26:0] fb_frac_o;
  logic [12:0] post_div_o;
  logic [2:0]  swing_a_o, swing_b_o;

  int total = 0, bad = 0;

  always #4 clk_i = ~clk_i;

  osc_reprog_ctrl #(.LOCK_TIMEOUT(TMO)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // writes are driven at a falling edge and accepted at the next rising edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  function automatic logic [15:0] hi_word(input logic [4:0] ti, input logic [26:0] fr);
    return {ti ^ 5'b01110, fr[26:16]};
  endfunction
  function automatic logic [15:0] post_word(input logic [12:0] tp, input logic [2:0] sw);
    return {tp ^ 13'h001B, sw};
  endfunction

  task automatic t_reset;
    chk("R1 out_en", out_en_o, 1);
    chk("R1 apply", pll_apply_o, 0);
    chk("R1 errs", {err_range_o, err_lock_o}, 0);
    chk("R1 fb", {fb_int_o, fb_frac_o}, 0);
    chk("R1 post/mode", {post_div_o, drv_bypass_o, swing_a_o, swing_b_o}, 0);
  endtask

  task automatic t_program(input logic [4:0] ti, input logic [26:0] fr,
                           input logic [12:0] tp, input logic md, input logic [2:0] sa,
                           input logic [2:0] sb);
    pll_lock_i = 1'b0;
    wr(3'd3, hi_word(ti, fr));
    chk("R2 blank on upper word", out_en_o, 0);
    wr(3'd4, fr[15:0]);
    wr(3'd6, {12'h0, md, sb});
    chk("R7 swing b", swing_b_o, sb);
    wr(3'd5, post_word(tp, sa));
    chk("R3 apply pulse", pll_apply_o, 1);
    chk("R3 fb int", fb_int_o, ti);
    chk("R3 fb frac", fb_frac_o, fr);
    chk("R3 post", post_div_o, tp);
    chk("R3 bypass", drv_bypass_o, md);
    chk("R7 swing a", swing_a_o, sa);
    idle(1);
    chk("R3 pulse ends", pll_apply_o, 0);
    idle(3);
    chk("R4 no enable before lock", out_en_o, 0);
    pll_lock_i = 1'b1;
    idle(1);
    chk("R4 enable after lock", out_en_o, 1);
  endtask

  task automatic t_bad_post(input logic [12:0] tp);
    logic [12:0] prev_post;
    prev_post = post_div_o;
    wr(3'd3, hi_word(5'd14, 27'h0123456));
    wr(3'd5, post_word(tp, 3'd2));
    chk("R5 no apply", pll_apply_o, 0);
    chk("R5 err_range", err_range_o, 1);
    chk("R5 post kept", post_div_o, prev_post);
    chk("R7 swing on rejected", swing_a_o, 2);
    idle(3);
    chk("R5 output dark", out_en_o, 0);
  endtask

  task automatic t_timeout;
    pll_lock_i = 1'b0;
    wr(3'd5, post_word(13'd8191, 3'd0));
    chk("R8 err_range cleared", err_range_o, 0);
    chk("R3 max post", post_div_o, 13'd8191);
    idle(TMO - 1);
    chk("R6 no err before limit", err_lock_o, 0);
    idle(1);
    chk("R6 err_lock at limit", err_lock_o, 1);
    pll_lock_i = 1'b1;
    idle(2);
    chk("R6 stays dark", out_en_o, 0);
    pll_lock_i = 1'b0;
    wr(3'd5, post_word(13'd3, 3'd0));
    chk("R8 err_lock cleared", err_lock_o, 0);
    pll_lock_i = 1'b1;
    idle(1);
    chk("R4 recover", out_en_o, 1);
  endtask

  task automatic t_ignored;
    logic [63:0] snap;
    snap = {fb_int_o, fb_frac_o, post_div_o, drv_bypass_o, swing_a_o, swing_b_o, out_en_o};
    wr(3'd0, 16'hFFFF);
    wr(3'd1, 16'hFFFF);
    wr(3'd2, 16'hFFFF);
    wr(3'd7, 16'hFFFF);
    chk("R9 other addr", {fb_int_o, fb_frac_o, post_div_o, drv_bypass_o, swing_a_o,
        swing_b_o, out_en_o}, snap);
    chk("R9 no apply", pll_apply_o, 0);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(2);
    t_reset;
    rst_ni = 1'b1;
    idle(1);
    t_reset;
    t_program(5'd13, 27'h2630B2B, 13'd2, 1'b0, 3'd5, 3'd3);
    t_program(5'd15, 27'h7FFFFFF, 13'd4096, 1'b1, 3'd7, 3'd1);
    t_ignored;
    t_bad_post(13'd1);
    t_bad_post(13'd0);
    t_timeout;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule